// File: doc/BRIEF.md
# Store-Before-Load Ordering Monitor

This block watches a memory request interface and checks one rule for a single watched address: once a store to that address has been requested, a later load to the same address must not be serviced before the store is serviced. Four single-cycle strobes come in, and each has its own address: store request, store service, load request and load service. The block follows these strobes through a small sequence recognizer.

If the recognizer sees a load serviced ahead of a pending store, it enters a failure state and stays there. It raises a sticky error flag at the same time. After every legal store/load exchange the recognizer goes back to idle, so a violation that starts anywhere later in a trace is still caught.

The watched address is an input. It is captured only while the monitor is idle. Changing it in the middle of a pending sequence therefore does not disturb that sequence.

Top module: `store_load_order_chk`

## Requirements
- R1: While the synchronous reset `rst` is high, the monitor goes to idle (`state` = 2'd0) on the clock edge and clears `err`.
- R2: In idle, a store request whose address equals `watch_addr` moves `state` to store-pending (2'd1) on the next edge.
- R3: In store-pending, a load request to the captured address moves `state` to load-pending (2'd2), provided no store service to that address occurs in the same cycle.
- R4: In load-pending, a load service to the captured address moves `state` to failed (2'd3), provided no store service to that address occurs in the same cycle. `err` rises on that same edge.
- R5: In either pending state, a store service to the captured address returns `state` to idle (2'd0), so checking re-arms for a new sequence.
- R6: Once `state` is failed (2'd3), it stays failed on every following edge until reset, whatever the strobes do.
- R7: `err` is sticky. It is high exactly when `state` is failed.
- R8: A strobe whose address differs from the watched address does not change `state`.
- R9: `watch_addr` is captured only while idle. While a sequence is pending, the monitor compares against the value captured on the last idle cycle and ignores later changes of `watch_addr`.
- R10: When a store service and a load request or load service for the watched address arrive in the same cycle, the store service is evaluated first and `state` returns to idle.
- R11: In idle, load requests and load services have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| watch_addr | input | ADDR_W | Address to monitor, captured while idle |
| st_req | input | 1 | Store request strobe |
| st_req_addr | input | ADDR_W | Store request address |
| st_svc | input | 1 | Store service strobe |
| st_svc_addr | input | ADDR_W | Store service address |
| ld_req | input | 1 | Load request strobe |
| ld_req_addr | input | ADDR_W | Load request address |
| ld_svc | input | 1 | Load service strobe |
| ld_svc_addr | input | ADDR_W | Load service address |
| err | output | 1 | Sticky ordering-violation flag |
| state | output | 2 | Recognizer state: 0 idle, 1 store-pending, 2 load-pending, 3 failed |

## Verification
The store service can arrive in the same cycle as a load request while the store is pending, or in the same cycle as a load service while the load is pending. These two collisions decide whether the monitor re-arms or fails. The stimulus table holds both collisions, each reached from a fresh store/load sequence. A correct result is a return to idle with `err` still low. The opposite outcome, a move to load-pending or to failed, reveals that the wrong event was given priority.

// File: rtl/store_load_order_chk.sv
module store_load_order_chk #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] watch_addr,
  input  logic              st_req,
  input  logic [ADDR_W-1:0] st_req_addr,
  input  logic              st_svc,
  input  logic [ADDR_W-1:0] st_svc_addr,
  input  logic              ld_req,
  input  logic [ADDR_W-1:0] ld_req_addr,
  input  logic              ld_svc,
  input  logic [ADDR_W-1:0] ld_svc_addr,
  output logic              err,
  output logic [1:0]        state
);

  localparam logic [1:0] S_IDLE = 2'd0;
  localparam logic [1:0] S_ST   = 2'd1;
  localparam logic [1:0] S_LD   = 2'd2;
  localparam logic [1:0] S_BAD  = 2'd3;

  logic [ADDR_W-1:0] tgt;
  logic [ADDR_W-1:0] cmp;
  logic [1:0]        nxt;
  logic              hit_st_req, hit_st_svc, hit_ld_req, hit_ld_svc;

  assign cmp        = (state == S_IDLE) ? watch_addr : tgt;
  assign hit_st_req = st_req && (st_req_addr == cmp);
  assign hit_st_svc = st_svc && (st_svc_addr == cmp);
  assign hit_ld_req = ld_req && (ld_req_addr == cmp);
  assign hit_ld_svc = ld_svc && (ld_svc_addr == cmp);

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE: if (hit_st_req) nxt = S_ST;
      S_ST: begin
        if (hit_st_svc)      nxt = S_IDLE;
        else if (hit_ld_req) nxt = S_LD;
      end
      S_LD: begin
        if (hit_st_svc)      nxt = S_IDLE;
        else if (hit_ld_svc) nxt = S_BAD;
      end
      default: nxt = S_BAD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      err   <= 1'b0;
      tgt   <= '0;
    end else begin
      state <= nxt;
      err   <= err | (nxt == S_BAD);
      if (state == S_IDLE) tgt <= watch_addr;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (state == S_IDLE && !err));

  assert_store_arms_R2: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && st_req && st_req_addr == watch_addr) |=> state == S_ST);

  assert_load_pends_R3: assert property (@(posedge clk) disable iff (rst)
    (state == S_ST && ld_req && ld_req_addr == tgt &&
     !(st_svc && st_svc_addr == tgt)) |=> state == S_LD);

  assert_violation_flags_R4: assert property (@(posedge clk) disable iff (rst)
    (state == S_LD && ld_svc && ld_svc_addr == tgt &&
     !(st_svc && st_svc_addr == tgt)) |=> (state == S_BAD && err));

  assert_store_rearms_R5: assert property (@(posedge clk) disable iff (rst)
    ((state == S_ST || state == S_LD) && st_svc && st_svc_addr == tgt)
    |=> state == S_IDLE);

  assert_bad_absorbs_R6: assert property (@(posedge clk) disable iff (rst)
    state == S_BAD |=> state == S_BAD);

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  assert_err_matches_R7: assert property (@(posedge clk) disable iff (rst)
    err == (state == S_BAD));

  assert_target_held_R9: assert property (@(posedge clk) disable iff (rst)
    (state == S_ST || state == S_LD) |=> tgt == $past(tgt));

  assert_idle_loads_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && !(st_req && st_req_addr == watch_addr)) |=> state == S_IDLE);

endmodule

// File: tb/test_store_load_order_chk.sv
`timescale 1ns/1ps
module test_store_load_order_chk;
  localparam int AW = 8;
  localparam logic [AW-1:0] W0 = 8'h5A;
  localparam logic [AW-1:0] W1 = 8'h33;

  logic clk = 1'b0;
  logic rst;
  logic [AW-1:0] watch_addr;
  logic st_req, st_svc, ld_req, ld_svc;
  logic [AW-1:0] st_req_addr, st_svc_addr, ld_req_addr, ld_svc_addr;
  logic err;
  logic [1:0] state;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  store_load_order_chk #(.ADDR_W(AW)) i_store_load_order_chk (
    .clk(clk), .rst(rst), .watch_addr(watch_addr),
    .st_req(st_req), .st_req_addr(st_req_addr),
    .st_svc(st_svc), .st_svc_addr(st_svc_addr),
    .ld_req(ld_req), .ld_req_addr(ld_req_addr),
    .ld_svc(ld_svc), .ld_svc_addr(ld_svc_addr),
    .err(err), .state(state));

  // [9:6] strobes st_req,st_svc,ld_req,ld_svc; [5:2] address-miss per strobe; [1:0] expected state
  localparam int NV = 20;
  localparam logic [9:0] VEC [NV] = '{
    10'b1000_0000_01, // R2
    10'b0010_0010_01, // R8
    10'b0010_0000_10, // R3
    10'b0100_0100_10, // R8
    10'b0001_0001_10, // R8
    10'b0100_0000_00, // R5
    10'b0001_0000_00, // R11
    10'b1000_0000_01, // R2
    10'b0110_0000_00, // R10 store service with load request
    10'b1000_0000_01,
    10'b0010_0000_10,
    10'b0101_0000_00, // R10 store service with load service
    10'b1000_1000_00, // R8
    10'b1000_0000_01,
    10'b0100_0000_00, // R5
    10'b1000_0000_01,
    10'b0010_0000_10,
    10'b0001_0000_11, // R4
    10'b0100_0000_11, // R6
    10'b0000_0000_11  // R6
  };

  task automatic check(input string req, input logic [1:0] exp_st, input logic exp_err);
    total++;
    if (state !== exp_st || err !== exp_err) begin
      bad++;
      $display("FAIL %s: state=%0d err=%0b expected state=%0d err=%0b",
               req, state, err, exp_st, exp_err);
    end
  endtask

  task automatic drive(input logic [3:0] s, input logic [3:0] m, input logic [AW-1:0] w);
    @(negedge clk);
    {st_req, st_svc, ld_req, ld_svc} = s;
    st_req_addr = m[3] ? ~w : w;
    st_svc_addr = m[2] ? ~w : w;
    ld_req_addr = m[1] ? ~w : w;
    ld_svc_addr = m[0] ? ~w : w;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    {st_req, st_svc, ld_req, ld_svc} = 4'b0;
    @(posedge clk);
    #1;
    check("R1", 2'd0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    rst = 1'b1;
    watch_addr = W0;
    {st_req, st_svc, ld_req, ld_svc} = 4'b0;
    st_req_addr = '0; st_svc_addr = '0; ld_req_addr = '0; ld_svc_addr = '0;
    repeat (2) @(posedge clk);
    #1;
    check("R1", 2'd0, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][9:6], VEC[i][5:2], W0);
      check($sformatf("R2-table row %0d (R7)", i), VEC[i][1:0], VEC[i][1:0] == 2'd3);
    end

    do_reset(); // R1 clears a failed monitor

    // R9: target captured while idle, later watch_addr changes ignored
    drive(4'b1000, 4'b0000, W0);
    check("R9", 2'd1, 1'b0);
    watch_addr = W1;
    drive(4'b0010, 4'b0000, W0);
    check("R9", 2'd2, 1'b0);
    drive(4'b0001, 4'b0000, W1);
    check("R9", 2'd2, 1'b0);
    drive(4'b0100, 4'b0000, W0);
    check("R9", 2'd0, 1'b0);
    drive(4'b1000, 4'b0000, W1);
    check("R9", 2'd1, 1'b0);
    drive(4'b0010, 4'b0000, W1);
    check("R3", 2'd2, 1'b0);
    drive(4'b0001, 4'b0000, W1);
    check("R4", 2'd3, 1'b1);
    drive(4'b0000, 4'b0000, W1);
    check("R6", 2'd3, 1'b1);
    do_reset();

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run hung");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule